// File: doc/BRIEF.md
# Speculative Read-Set Dependency Tracker

This unit sits beside a data cache and follows one speculative transaction at a time on a snooping bus. Each load the transaction issues records its address in a small fully associative read-set array. The single store that ends the transaction goes into a one-entry write buffer. The transaction then waits for its turn to commit.

Commit turns follow a running next-to-commit count. The count moves forward by one for every write broadcast on the bus, whether this tracker sent it or snooped it. When the count equals the tracker's sequence number, the buffered write is broadcast and all tracked state is dropped.

A snooped remote write that hits any tracked read address aborts the transaction. The read set and the buffered write are discarded in a single cycle, and a restart request is sent back to the requester.

Top module: `specTracker`

## Requirements
- R1: After reset no write is pending, no broadcast or restart is signalled, no load is stalled, and the next-to-commit count is zero.
- R2: A load takes the lowest free read-set entry. A load to an address already tracked takes no new entry. When all entries are in use, a load to a new address raises ldStall in that same cycle and is not recorded.
- R3: A store accepted while no write is pending raises stPending in the next cycle. While a write is pending, further stores are ignored and every load raises ldStall.
- R4: A snooped write whose address matches a tracked read address aborts the transaction. restartPulse is high in the cycle after the match, and both the read set and the write buffer are empty afterwards.
- R5: A snooped write that matches no tracked address changes neither restartPulse nor the tracked state.
- R6: The next-to-commit count starts at 0. It rises by one for each commit this tracker makes and by one for each snooped bus write. A pending write commits only in a cycle where seqNum equals the count.
- R7: A granted commit drives bcValid high for exactly one cycle, starting in the cycle after the grant, with the buffered address and data on bcAddr and bcData. It also empties the read set and the write buffer.
- R8: If a matching snoop and an eligible commit fall in the same cycle, the abort wins: no broadcast occurs and the write is discarded.
- R9: restartPulse is a single-cycle pulse for each abort.
- R10: A load or a store presented in the same cycle as an abort is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | Load issued by the transaction |
| ldAddr | input | AW | Load address |
| ldStall | output | 1 | Load not accepted this cycle (combinational) |
| stValid | input | 1 | Terminating store issued |
| stAddr | input | AW | Store address |
| stData | input | DW | Store data |
| stPending | output | 1 | Write buffer holds an uncommitted store |
| seqNum | input | SW | Commit position of this transaction |
| snpValid | input | 1 | Remote write seen on the bus |
| snpAddr | input | AW | Remote write address |
| bcValid | output | 1 | Commit broadcast strobe |
| bcAddr | output | AW | Broadcast address |
| bcData | output | DW | Broadcast data |
| restartPulse | output | 1 | Request to restart the transaction |

## Verification
If a read-set entry is left valid when it should have been cleared, a later snoop to that address produces a restart the bench does not expect, one cycle after the snoop. The reverse case, an address the tracker has lost, shows up as a missing restart. If the next-to-commit count drifts, a commit comes early or late, and the scoreboard catches this as a broadcast that should not have happened or one that never arrives. A write buffer that stays live after an abort shows up right away on stPending and later as an extra broadcast. An entry that is never freed shows up as ldStall on a load that should have been accepted.

// File: rtl/specTrackPkg.sv
`timescale 1ns/1ps
package specTrackPkg;
  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic allocEn;   // record ldAddr in the lowest free entry
    logic clearAll;  // drop read set and write buffer
    logic wbLoad;    // capture the terminating store
    logic bcFire;    // broadcast the buffered write next cycle
  } trkStrobes_t;
endpackage

// File: rtl/specTrackData.sv
`timescale 1ns/1ps
module specTrackData
  import specTrackPkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  trkStrobes_t   ctrl,
  input  logic [AW-1:0] ldAddr,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  input  logic          snpValid,
  input  logic [AW-1:0] snpAddr,
  output logic          snoopHit,
  output logic          ldPresent,
  output logic          rsFull,
  output logic          stPending,
  output logic          bcValid,
  output logic [AW-1:0] bcAddr,
  output logic [DW-1:0] bcData
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] snoopMatch;
  logic [ENTRIES-1:0] loadMatch;
  logic [ENTRIES-1:0] allocOh;
  logic [IW-1:0]      allocIdx;

  // Lowest free entry: scan downward so the smallest index wins.
  always_comb begin
    allocIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) allocIdx = IW'(i);
    end
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
      logic          entValid;
      logic [AW-1:0] entTag;

      assign allocOh[g] = (allocIdx == IW'(g)) && !entValid;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          entValid <= 1'b0;
          entTag   <= '0;
        end else if (ctrl.clearAll) begin
          entValid <= 1'b0;
        end else if (ctrl.allocEn && allocOh[g]) begin
          entValid <= 1'b1;
          entTag   <= ldAddr;
        end
      end

      assign validVec[g]   = entValid;
      assign snoopMatch[g] = entValid && (entTag == snpAddr);
      assign loadMatch[g]  = entValid && (entTag == ldAddr);
    end
  endgenerate

  assign snoopHit  = snpValid && (|snoopMatch);
  assign ldPresent = |loadMatch;
  assign rsFull    = &validVec;

  // One-entry write buffer for the terminating store.
  logic [AW-1:0] wbAddr;
  logic [DW-1:0] wbData;
  logic          wbValid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbValid <= 1'b0;
      wbAddr  <= '0;
      wbData  <= '0;
    end else if (ctrl.clearAll) begin
      wbValid <= 1'b0;
    end else if (ctrl.wbLoad) begin
      wbValid <= 1'b1;
      wbAddr  <= stAddr;
      wbData  <= stData;
    end
  end

  assign stPending = wbValid;

  // Broadcast register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcValid <= 1'b0;
      bcAddr  <= '0;
      bcData  <= '0;
    end else begin
      bcValid <= ctrl.bcFire;
      if (ctrl.bcFire) begin
        bcAddr <= wbAddr;
        bcData <= wbData;
      end
    end
  end

  AST_ALLOC_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.allocEn |-> !rsFull); // R2
  AST_BUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wbValid && !ctrl.clearAll) |=> ($stable(wbAddr) && $stable(wbData))); // R3
  AST_ABORT_BEATS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.bcFire |-> !snoopHit); // R8
  AST_BC_CLEARS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    bcValid |-> !wbValid); // R7
endmodule

// File: rtl/specTrackCtrl.sv
`timescale 1ns/1ps
module specTrackCtrl
  import specTrackPkg::*;
#(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ldValid,
  input  logic          stValid,
  input  logic [SW-1:0] seqNum,
  input  logic          snpValid,
  input  logic          snoopHit,
  input  logic          ldPresent,
  input  logic          rsFull,
  input  logic          stPending,
  output trkStrobes_t   ctrl,
  output logic          ldStall,
  output logic          restartPulse
);
  logic [SW-1:0] nextCnt;
  logic          abortHit;
  logic          grant;

  assign abortHit = snoopHit;
  assign grant    = stPending && (seqNum == nextCnt) && !abortHit;
  assign ldStall  = ldValid && (stPending || (rsFull && !ldPresent));

  always_comb begin
    ctrl          = '0;
    ctrl.allocEn  = ldValid && !ldStall && !ldPresent && !abortHit;
    ctrl.wbLoad   = stValid && !stPending && !abortHit;
    ctrl.clearAll = abortHit || grant;
    ctrl.bcFire   = grant;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nextCnt      <= '0;
      restartPulse <= 1'b0;
    end else begin
      nextCnt      <= nextCnt + SW'(grant) + SW'(snpValid);
      restartPulse <= abortHit;
    end
  end

  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    restartPulse |=> !restartPulse); // R9
  AST_RESTART_FROM_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    restartPulse |-> $past(snpValid)); // R4
endmodule

// File: rtl/specTracker.sv
`timescale 1ns/1ps
module specTracker
  import specTrackPkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ldValid,
  input  logic [AW-1:0] ldAddr,
  output logic          ldStall,
  input  logic          stValid,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  output logic          stPending,
  input  logic [SW-1:0] seqNum,
  input  logic          snpValid,
  input  logic [AW-1:0] snpAddr,
  output logic          bcValid,
  output logic [AW-1:0] bcAddr,
  output logic [DW-1:0] bcData,
  output logic          restartPulse
);
  trkStrobes_t ctrl;
  logic snoopHit, ldPresent, rsFull;

  specTrackCtrl #(.SW(SW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .ldValid(ldValid), .stValid(stValid),
    .seqNum(seqNum), .snpValid(snpValid), .snoopHit(snoopHit),
    .ldPresent(ldPresent), .rsFull(rsFull), .stPending(stPending),
    .ctrl(ctrl), .ldStall(ldStall), .restartPulse(restartPulse)
  );

  specTrackData #(.ENTRIES(ENTRIES), .AW(AW), .DW(DW)) data_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .ldAddr(ldAddr),
    .stAddr(stAddr), .stData(stData), .snpValid(snpValid),
    .snpAddr(snpAddr), .snoopHit(snoopHit), .ldPresent(ldPresent),
    .rsFull(rsFull), .stPending(stPending), .bcValid(bcValid),
    .bcAddr(bcAddr), .bcData(bcData)
  );
endmodule

// File: tb/specTracker_tb.sv
`timescale 1ns/1ps
module specTracker_tb_top;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ldValid = 1'b0, stValid = 1'b0, snpValid = 1'b0;
  logic [AW-1:0] ldAddr = '0, stAddr = '0, snpAddr = '0;
  logic [DW-1:0] stData = '0;
  logic [SW-1:0] seqNum = '0;
  logic ldStall, stPending, bcValid, restartPulse;
  logic [AW-1:0] bcAddr;
  logic [DW-1:0] bcData;

  always #2.5 clk = ~clk;

  specTracker dut_i (
    .clk(clk), .rst_n(rst_n), .ldValid(ldValid), .ldAddr(ldAddr),
    .ldStall(ldStall), .stValid(stValid), .stAddr(stAddr), .stData(stData),
    .stPending(stPending), .seqNum(seqNum), .snpValid(snpValid),
    .snpAddr(snpAddr), .bcValid(bcValid), .bcAddr(bcAddr), .bcData(bcData),
    .restartPulse(restartPulse)
  );

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } bcItem_t;
  bcItem_t expQ[$];
  int nChecks = 0;
  int nBad = 0;
  bit doneFlag = 0;

  task automatic check(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doLoad(input logic [AW-1:0] a);
    ldValid = 1'b1; ldAddr = a;
    #1 check("R2", "stall on accepted load", ldStall, 0);
    tick();
    ldValid = 1'b0;
  endtask

  task automatic doSnoop(input logic [AW-1:0] a);
    snpValid = 1'b1; snpAddr = a;
    tick();
    snpValid = 1'b0;
  endtask

  task automatic expectBc(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bcItem_t it;
    it.a = a; it.d = d;
    expQ.push_back(it);
  endtask

  // Monitor: every broadcast must match the head of the expected queue.
  always @(negedge clk) begin
    if (rst_n && bcValid) begin
      if (expQ.size() == 0) begin
        check("R6", "unexpected broadcast addr", bcAddr, 32'hFFFF_FFFF);
      end else begin
        bcItem_t it;
        it = expQ.pop_front();
        check("R7", "broadcast addr", bcAddr, it.a);
        check("R7", "broadcast data", bcData, it.d);
      end
    end
  end

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!doneFlag) begin
      check("R1", "watchdog expired", 1, 0);
      finishRun();
    end
  end

  initial begin
    int stallCnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "stPending", stPending, 0);
    check("R1", "bcValid", bcValid, 0);
    check("R1", "restartPulse", restartPulse, 0);
    check("R1", "ldStall", ldStall, 0);

    // R3 / R6: store waits while seqNum differs from count 0
    seqNum = 4'd5;
    doLoad(16'h0010); doLoad(16'h0011); doLoad(16'h0012);
    stValid = 1'b1; stAddr = 16'h0080; stData = 16'hBEEF;
    tick(); stValid = 1'b0;
    check("R3", "stPending after store", stPending, 1);
    tick(); tick();
    ldValid = 1'b1; ldAddr = 16'h0013;
    #1 check("R3", "load stalls while write pending", ldStall, 1);
    tick(); ldValid = 1'b0;
    stValid = 1'b1; stAddr = 16'h0090; stData = 16'h1234;
    tick(); stValid = 1'b0;
    // R6 / R7: matching seqNum grants, first store's data broadcast
    expectBc(16'h0080, 16'hBEEF);
    seqNum = 4'd0;
    tick(); tick(); tick();
    check("R7", "buffer empty after commit", stPending, 0);
    check("R7", "queue drained after commit", expQ.size(), 0);
    // count now 1

    // R2: fill read set
    seqNum = 4'd9;
    for (int i = 0; i < 8; i++) doLoad(16'h0020 + 16'(i));
    ldValid = 1'b1; ldAddr = 16'h0023;
    #1 check("R2", "tracked address not stalled when full", ldStall, 0);
    tick();
    ldAddr = 16'h0028;
    #1 check("R2", "new address stalls when full", ldStall, 1);
    tick(); ldValid = 1'b0;
    // R5: non-matching snoop
    doSnoop(16'h0099);
    check("R5", "no restart on miss", restartPulse, 0);
    // R2: stalled load was not recorded
    doSnoop(16'h0028);
    check("R2", "stalled load not tracked", restartPulse, 0);
    // R4 / R9: matching snoop
    doSnoop(16'h0025);
    check("R4", "restart after match", restartPulse, 1);
    tick();
    check("R9", "restart lasts one cycle", restartPulse, 0);
    // R4: read set cleared -> eight fresh loads fit
    stallCnt = 0;
    for (int i = 0; i < 8; i++) begin
      ldValid = 1'b1; ldAddr = 16'h0030 + 16'(i);
      #1 if (ldStall) stallCnt++;
      tick();
    end
    ldValid = 1'b0;
    check("R4", "stalls after abort cleared set", stallCnt, 0);
    // count now 4

    // R8: abort beats eligible commit
    stValid = 1'b1; stAddr = 16'h00A0; stData = 16'h5555;
    tick(); stValid = 1'b0;
    check("R3", "stPending before race", stPending, 1);
    seqNum = 4'd4;
    doSnoop(16'h0031);
    check("R8", "restart wins race", restartPulse, 1);
    check("R8", "write discarded", stPending, 0);
    seqNum = 4'd9;
    tick();
    // count now 5

    // R10: load and store in abort cycle dropped
    doLoad(16'h0040);
    snpValid = 1'b1; snpAddr = 16'h0040;
    stValid = 1'b1; stAddr = 16'h00B0; stData = 16'h7777;
    ldValid = 1'b1; ldAddr = 16'h0041;
    tick();
    snpValid = 1'b0; stValid = 1'b0; ldValid = 1'b0;
    check("R10", "restart on abort", restartPulse, 1);
    check("R10", "store dropped", stPending, 0);
    tick();
    doSnoop(16'h0041);
    check("R10", "load dropped", restartPulse, 0);
    // count now 7

    // R6: count tracks own and snooped commits
    seqNum = 4'd7;
    expectBc(16'h00C0, 16'hCAFE);
    stValid = 1'b1; stAddr = 16'h00C0; stData = 16'hCAFE;
    tick(); stValid = 1'b0;
    tick(); tick();
    check("R6", "commit at count 7", expQ.size(), 0);
    // count now 8
    seqNum = 4'd9;
    stValid = 1'b1; stAddr = 16'h00D0; stData = 16'hD00D;
    tick(); stValid = 1'b0;
    tick(); tick();
    check("R6", "held at count 8", stPending, 1);
    expectBc(16'h00D0, 16'hD00D);
    doSnoop(16'h0077);
    tick(); tick();
    check("R6", "commit after snooped count step", expQ.size(), 0);
    check("R7", "buffer empty", stPending, 0);

    doneFlag = 1;
    finishRun();
  end
endmodule